// File: doc/BRIEF.md
# Flash Read Port with Cache Modes

This block sits between a processor read bus and a flash array. Each read request is checked against a small direct-mapped cache of single-word lines. A hit can be answered from the cache. A miss, or any read while the cache is switched off, goes to the array. Every array access is stretched by a programmable number of wait states so that data is valid at high clock rates. A read-timing policy decides what a hit or a miss costs: no miss penalty, one extra wait state per miss to save power, or fixed timing in which a hit and a miss take the same number of cycles.

The block also manages the array's reduced-power state. A sleep policy sets how the array leaves that state after the device sleeps: on the first array access, as soon as the device wakes, or never entering it at all. An explicit enter command puts the array to sleep and holds off all requests until the matching exit command arrives. Leaving the reduced-power state adds a fixed number of wake cycles to the next array access.

Configuration fields are captured only on a load strobe. Requests use a valid/ready handshake. Each response is a one-cycle valid pulse with its data word.

Top module: `flash_read_port`

## Requirements
- R1: After reset the port is ready, no response or array read is active, and the array is awake. The captured configuration is 0 wait states, cache on, read policy 0 and sleep policy 0 (wake on access).
- R2: Let L be the number of rising edges from the accepting edge to the edge that raises rspValid. Let W be the captured wait-state count. An array read without a wake penalty takes L = W+2 under policies 0 and 3. The data returned is the array word at the request address, and arrAddr is held steady while arrRdEn is high.
- R3: With the cache switched off, every read asserts arrRdEn and takes L = W+2, including a repeat of the same address.
- R4: Under read policy 0 (no miss penalty), a miss takes L = W+2 and a hit takes L = 1. A hit returns the cached word and does not assert arrRdEn.
- R5: Under read policy 1 (low power), a miss takes L = W+3 and a hit takes L = 1.
- R6: Under read policy 2 (fixed timing), a hit and a miss both take L = W+2, and a hit does not assert arrRdEn.
- R7: The cache line index is reqAddr[2:0] for the default eight lines, and the rest of the address is the tag. A read whose tag differs from the tag stored in that line is a miss and replaces the line.
- R8: Capturing cache-off invalidates every line, so after the cache is turned back on a previously cached address misses.
- R9: Under sleep policy 0, device sleep sets arrSleep on the next edge and it stays set after the device wakes. A cache hit leaves it set. The first array access adds WAKE_CYC cycles and clears it, and later misses pay no penalty.
- R10: Under sleep policy 1 (wake instantly), arrSleep clears on the edge after devSleep falls, and the next array access adds WAKE_CYC cycles.
- R11: Under sleep policy 2 or 3 (never sleep), devSleep does not set arrSleep, and array reads pay no wake penalty.
- R12: lpEnter sets arrSleep and drops reqReady on the next edge. No request is accepted until lpExit. lpExit clears arrSleep on the next edge, and the next array access adds WAKE_CYC cycles.
- R13: rspValid lasts exactly one cycle. reqReady is low from the accepting edge until the cycle after the response.
- R14: The configuration inputs have no effect until cfgLoad is high at a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Read request valid |
| reqReady | output | 1 | Port can accept a request |
| reqAddr | input | AW | Word address of the read |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | DW | Read data, valid with rspValid |
| cfgLoad | input | 1 | Capture the configuration fields |
| cfgWaitStates | input | WS_W | Wait states per array access |
| cfgCacheOff | input | 1 | 1 switches the cache off and invalidates it |
| cfgReadMode | input | 2 | 0 no penalty, 1 low power, 2 fixed timing, 3 as 0 |
| cfgSleepMode | input | 2 | 0 wake on access, 1 wake instantly, 2 and 3 never sleep |
| lpEnter | input | 1 | Command: enter reduced power |
| lpExit | input | 1 | Command: leave reduced power |
| devSleep | input | 1 | Device is asleep |
| arrRdEn | output | 1 | Array read window active |
| arrAddr | output | AW | Array word address |
| arrRdata | input | DW | Array read data |
| arrSleep | output | 1 | Array is in its reduced-power state |

## Verification
Reads are issued as address sequences that produce cold misses, repeat hits, and conflicting tags that share one line index. The measured response latency, together with whether arrRdEn was raised, tells a hit from a miss under each read policy. The same cached address is re-read after cache-off, cache-on and policy changes, which shows whether lines were invalidated or kept and whether fixed-timing hits hide their speed. Sleep sequences under each sleep policy and the enter/exit commands are followed by one hit and two misses, which shows which access pays the wake cost and that it is paid only once.

// File: rtl/frp_pkg.sv
package frp_pkg;

  typedef enum logic [1:0] {
    RM_NOPEN  = 2'd0,
    RM_LOWPWR = 2'd1,
    RM_FIXED  = 2'd2,
    RM_ALT    = 2'd3
  } readMode_e;

  typedef enum logic [1:0] {
    SM_ON_ACCESS = 2'd0,
    SM_INSTANT   = 2'd1,
    SM_NEVER     = 2'd2,
    SM_NEVER_ALT = 2'd3
  } sleepMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } portState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;     // request accepted this edge
    logic hitLoad;  // load response from cache line
    logic arrLoad;  // load response from array
    logic fill;     // write array word into cache line
    logic flush;    // clear all valid bits
  } dpCtl_t;

endpackage

// File: rtl/frp_ctrl.sv
module frp_ctrl
  import frp_pkg::*;
#(
  parameter int WS_W     = 4,
  parameter int WAKE_CYC = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  output logic            rspValid,
  input  logic            cfgLoad,
  input  logic [WS_W-1:0] cfgWaitStates,
  input  logic            cfgCacheOff,
  input  logic [1:0]      cfgReadMode,
  input  logic [1:0]      cfgSleepMode,
  input  logic            lpEnter,
  input  logic            lpExit,
  input  logic            devSleep,
  input  logic            lineHit,
  output dpCtl_t          ctl,
  output logic            arrRdEn,
  output logic            arrSleep
);

  localparam int MAX_LAT = (2 ** WS_W) - 1 + 3 + WAKE_CYC;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [WS_W-1:0]  wsQ;
  logic             offQ;
  readMode_e        rmQ;
  sleepMode_e       smQ;
  portState_e       stQ;
  logic [CNT_W-1:0] cntQ;
  logic             useArrQ;
  logic             sleepQ, coldQ, lockQ, devSleepQ;

  logic             hit, take, needArr, wake, lastWait;
  logic [CNT_W-1:0] baseLat, latNow;

  assign hit      = lineHit && !offQ;
  assign reqReady = (stQ == ST_IDLE) && !lockQ;
  assign take     = reqValid && reqReady;
  assign needArr  = !hit;
  assign wake     = needArr && (sleepQ || coldQ);
  assign lastWait = (stQ == ST_WAIT) && (cntQ == CNT_W'(1));

  always_comb begin
    baseLat = CNT_W'(wsQ) + CNT_W'(2);
    if (offQ || rmQ == RM_FIXED) latNow = baseLat;
    else if (hit)                latNow = CNT_W'(1);
    else if (rmQ == RM_LOWPWR)   latNow = baseLat + CNT_W'(1);
    else                         latNow = baseLat;
    if (wake) latNow = latNow + CNT_W'(WAKE_CYC);
  end

  always_comb begin
    ctl.take    = take;
    ctl.hitLoad = take && hit;
    ctl.arrLoad = lastWait && useArrQ;
    ctl.fill    = lastWait && useArrQ && !offQ;
    ctl.flush   = offQ;
  end

  assign arrRdEn  = (stQ == ST_WAIT) && useArrQ;
  assign rspValid = (stQ == ST_RESP);
  assign arrSleep = sleepQ;

  // captured configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsQ  <= '0;
      offQ <= 1'b0;
      rmQ  <= RM_NOPEN;
      smQ  <= SM_ON_ACCESS;
    end else if (cfgLoad) begin
      wsQ  <= cfgWaitStates;
      offQ <= cfgCacheOff;
      rmQ  <= readMode_e'(cfgReadMode);
      smQ  <= sleepMode_e'(cfgSleepMode);
    end
  end

  // access sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ     <= ST_IDLE;
      cntQ    <= '0;
      useArrQ <= 1'b0;
    end else begin
      unique case (stQ)
        ST_IDLE: if (take) begin
          stQ     <= ST_WAIT;
          cntQ    <= latNow;
          useArrQ <= needArr;
        end
        ST_WAIT: begin
          if (cntQ == CNT_W'(1)) stQ <= ST_RESP;
          else                   cntQ <= cntQ - CNT_W'(1);
        end
        default: stQ <= ST_IDLE;
      endcase
    end
  end

  // reduced-power state; later assignments take priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepQ    <= 1'b0;
      coldQ     <= 1'b0;
      lockQ     <= 1'b0;
      devSleepQ <= 1'b0;
    end else begin
      devSleepQ <= devSleep;
      if (take && wake) begin
        sleepQ <= 1'b0;
        coldQ  <= 1'b0;
      end
      if (devSleep && (smQ == SM_ON_ACCESS || smQ == SM_INSTANT))
        sleepQ <= 1'b1;
      if (!devSleep && devSleepQ && smQ == SM_INSTANT) begin
        sleepQ <= 1'b0;
        coldQ  <= 1'b1;
      end
      if (lpEnter) begin
        sleepQ <= 1'b1;
        lockQ  <= 1'b1;
      end
      if (lpExit) begin
        sleepQ <= 1'b0;
        lockQ  <= 1'b0;
        coldQ  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/frp_datapath.sv
module frp_datapath
  import frp_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LINES = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] reqAddr,
  output logic          lineHit,
  output logic [AW-1:0] arrAddr,
  input  logic [DW-1:0] arrRdata,
  output logic [DW-1:0] rspData
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = AW - IDX_W;

  logic [AW-1:0]    addrQ;
  logic [DW-1:0]    rspQ;
  logic [LINES-1:0] validQ;
  logic [TAG_W-1:0] tagArr [LINES];
  logic [DW-1:0]    dataArr [LINES];

  logic [IDX_W-1:0] idxIn, idxQ;
  logic [TAG_W-1:0] tagIn;

  assign idxIn   = reqAddr[IDX_W-1:0];
  assign tagIn   = reqAddr[AW-1:IDX_W];
  assign idxQ    = addrQ[IDX_W-1:0];
  assign lineHit = validQ[idxIn] && (tagArr[idxIn] == tagIn);
  assign arrAddr = addrQ;
  assign rspData = rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      rspQ   <= '0;
      validQ <= '0;
    end else begin
      if (ctl.take)    addrQ <= reqAddr;
      if (ctl.hitLoad) rspQ  <= dataArr[idxIn];
      if (ctl.arrLoad) rspQ  <= arrRdata;
      if (ctl.flush)     validQ       <= '0;
      else if (ctl.fill) validQ[idxQ] <= 1'b1;
    end
  end

  // line storage, one slot per index
  for (genvar g = 0; g < LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (ctl.fill && idxQ == IDX_W'(g)) begin
        tagArr[g]  <= addrQ[AW-1:IDX_W];
        dataArr[g] <= arrRdata;
      end
    end
  end

endmodule

// File: rtl/flash_read_port.sv
module flash_read_port
  import frp_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int LINES    = 8,
  parameter int WS_W     = 4,
  parameter int WAKE_CYC = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [AW-1:0]   reqAddr,
  output logic            rspValid,
  output logic [DW-1:0]   rspData,
  input  logic            cfgLoad,
  input  logic [WS_W-1:0] cfgWaitStates,
  input  logic            cfgCacheOff,
  input  logic [1:0]      cfgReadMode,
  input  logic [1:0]      cfgSleepMode,
  input  logic            lpEnter,
  input  logic            lpExit,
  input  logic            devSleep,
  output logic            arrRdEn,
  output logic [AW-1:0]   arrAddr,
  input  logic [DW-1:0]   arrRdata,
  output logic            arrSleep
);

  dpCtl_t ctl;
  logic   lineHit;

  frp_ctrl #(.WS_W(WS_W), .WAKE_CYC(WAKE_CYC)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .rspValid(rspValid),
    .cfgLoad(cfgLoad), .cfgWaitStates(cfgWaitStates), .cfgCacheOff(cfgCacheOff),
    .cfgReadMode(cfgReadMode), .cfgSleepMode(cfgSleepMode),
    .lpEnter(lpEnter), .lpExit(lpExit), .devSleep(devSleep),
    .lineHit(lineHit), .ctl(ctl), .arrRdEn(arrRdEn), .arrSleep(arrSleep)
  );

  frp_datapath #(.AW(AW), .DW(DW), .LINES(LINES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr),
    .lineHit(lineHit), .arrAddr(arrAddr), .arrRdata(arrRdata), .rspData(rspData)
  );

endmodule

// File: rtl/frp_checker.sv
module frp_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          rspValid,
  input logic          lpEnter,
  input logic          lpExit,
  input logic          arrRdEn,
  input logic [AW-1:0] arrAddr,
  input logic          arrSleep
);

  // R13
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R13
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R12
  enter_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lpEnter && !lpExit) |=> (arrSleep && !reqReady));

  // R12
  exit_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    lpExit |=> !arrSleep);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrRdEn |=> (!arrRdEn || $stable(arrAddr)));

endmodule

bind flash_read_port frp_checker #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .lpEnter(lpEnter), .lpExit(lpExit),
  .arrRdEn(arrRdEn), .arrAddr(arrAddr), .arrSleep(arrSleep)
);

// File: tb/flash_read_port_test.sv
`timescale 1ns/1ps
module flash_read_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        cfgLoad = 1'b0;
  logic [3:0]  cfgWaitStates = '0;
  logic        cfgCacheOff = 1'b0;
  logic [1:0]  cfgReadMode = '0;
  logic [1:0]  cfgSleepMode = '0;
  logic        lpEnter = 1'b0, lpExit = 1'b0, devSleep = 1'b0;
  logic        arrRdEn;
  logic [15:0] arrAddr;
  logic [31:0] arrRdata;
  logic        arrSleep;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  // array model
  assign arrRdata = {arrAddr ^ 16'h3C5A, ~arrAddr};

  flash_read_port uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspData(rspData),
    .cfgLoad(cfgLoad), .cfgWaitStates(cfgWaitStates), .cfgCacheOff(cfgCacheOff),
    .cfgReadMode(cfgReadMode), .cfgSleepMode(cfgSleepMode),
    .lpEnter(lpEnter), .lpExit(lpExit), .devSleep(devSleep),
    .arrRdEn(arrRdEn), .arrAddr(arrAddr), .arrRdata(arrRdata), .arrSleep(arrSleep)
  );

  function automatic logic [31:0] wordAt(input logic [15:0] a);
    return {a ^ 16'h3C5A, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setCfg(input int ws, input bit off, input int rm, input int sm);
    @(negedge clk);
    cfgWaitStates = 4'(ws); cfgCacheOff = off;
    cfgReadMode = 2'(rm); cfgSleepMode = 2'(sm); cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  // issue one read and measure edges from acceptance to response
  task automatic doRead(input logic [15:0] a, input int expLat, input bit expArr,
                        input string req);
    int  n;
    bit  sawArr;
    bit  leak;
    @(negedge clk);
    check(reqReady == 1'b1, req, "ready before read", reqReady, 1);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0; sawArr = arrRdEn; leak = 1'b0;
    while (!rspValid && n < 60) begin
      leak |= reqReady;
      @(negedge clk);
      n++;
      sawArr |= arrRdEn;
    end
    check(n == expLat, req, $sformatf("latency @%h", a), n, expLat);
    check(sawArr == expArr, req, $sformatf("array used @%h", a), sawArr, expArr);
    check(rspData == wordAt(a), req, $sformatf("data @%h", a), rspData, wordAt(a));
    check(!leak, "R13", "ready while busy", leak, 0);
    @(negedge clk);
    check(!rspValid && reqReady, "R13", "single pulse then ready",
          {rspValid, reqReady}, 2'b01);
  endtask

  // table run under policy 0, W=2: {address, latency, array used}
  localparam logic [24:0] VEC [8] = '{
    {16'h0010, 8'd4, 1'b1},  // cold miss
    {16'h0010, 8'd1, 1'b1 ^ 1'b1},  // hit
    {16'h0018, 8'd4, 1'b1},  // same index, other tag (R7)
    {16'h0010, 8'd4, 1'b1},  // evicted (R7)
    {16'h0011, 8'd4, 1'b1},
    {16'h0011, 8'd1, 1'b0},
    {16'h0018, 8'd4, 1'b1},
    {16'h0010, 8'd4, 1'b1}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R13 watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady", reqReady, 1);
    check(rspValid == 1'b0, "R1", "rspValid", rspValid, 0);
    check(arrSleep == 1'b0, "R1", "arrSleep", arrSleep, 0);
    check(arrRdEn == 1'b0, "R1", "arrRdEn", arrRdEn, 0);

    // R1 default sleep policy is wake on access
    devSleep = 1'b1;
    @(negedge clk);
    check(arrSleep == 1'b1, "R1", "sleep with default policy", arrSleep, 1);
    devSleep = 1'b0;
    @(negedge clk);
    check(arrSleep == 1'b1, "R1", "held after device wake", arrSleep, 1);

    // R14 fields without load are ignored: still W=0, cache on, policy 0
    cfgWaitStates = 4'd5; cfgCacheOff = 1'b1; cfgReadMode = 2'd2; cfgSleepMode = 2'd2;
    doRead(16'h0100, 2 + 4, 1'b1, "R14");
    doRead(16'h0100, 1, 1'b0, "R14");

    // R4 R7 table
    setCfg(2, 1'b0, 0, 0);
    for (int i = 0; i < 8; i++)
      doRead(VEC[i][24:9], int'(VEC[i][8:1]), VEC[i][0], "R4/R7");

    // R5 low-power policy
    setCfg(2, 1'b0, 1, 0);
    doRead(16'h0020, 5, 1'b1, "R5");
    doRead(16'h0020, 1, 1'b0, "R5");

    // R6 fixed timing
    setCfg(3, 1'b0, 2, 0);
    doRead(16'h0020, 5, 1'b0, "R6");
    doRead(16'h0033, 5, 1'b1, "R6");

    // R3 cache off
    setCfg(1, 1'b1, 0, 0);
    doRead(16'h0020, 3, 1'b1, "R3");
    doRead(16'h0020, 3, 1'b1, "R3");

    // R8 invalidated lines miss after re-enable
    setCfg(1, 1'b0, 0, 0);
    doRead(16'h0020, 3, 1'b1, "R8");
    doRead(16'h0020, 1, 1'b0, "R8");

    // R9 wake on access
    @(negedge clk); devSleep = 1'b1;
    @(negedge clk); check(arrSleep == 1'b1, "R9", "asleep", arrSleep, 1);
    devSleep = 1'b0;
    @(negedge clk); check(arrSleep == 1'b1, "R9", "held", arrSleep, 1);
    doRead(16'h0020, 1, 1'b0, "R9");
    check(arrSleep == 1'b1, "R9", "hit keeps sleep", arrSleep, 1);
    doRead(16'h0041, 3 + 4, 1'b1, "R9");
    check(arrSleep == 1'b0, "R9", "woken by access", arrSleep, 0);
    doRead(16'h0042, 3, 1'b1, "R9");

    // R10 wake instantly
    setCfg(1, 1'b0, 0, 1);
    @(negedge clk); devSleep = 1'b1;
    @(negedge clk); check(arrSleep == 1'b1, "R10", "asleep", arrSleep, 1);
    devSleep = 1'b0;
    @(negedge clk); check(arrSleep == 1'b0, "R10", "woken with device", arrSleep, 0);
    doRead(16'h0045, 3 + 4, 1'b1, "R10");
    doRead(16'h0046, 3, 1'b1, "R10");

    // R11 never sleep
    setCfg(1, 1'b0, 0, 2);
    @(negedge clk); devSleep = 1'b1;
    @(negedge clk); check(arrSleep == 1'b0, "R11", "no sleep", arrSleep, 0);
    @(negedge clk); check(arrSleep == 1'b0, "R11", "still awake", arrSleep, 0);
    devSleep = 1'b0;
    doRead(16'h0047, 3, 1'b1, "R11");

    // R12 explicit enter / exit
    @(negedge clk); lpEnter = 1'b1;
    @(negedge clk); lpEnter = 1'b0;
    check(arrSleep == 1'b1, "R12", "entered", arrSleep, 1);
    check(reqReady == 1'b0, "R12", "locked", reqReady, 0);
    reqValid = 1'b1; reqAddr = 16'h0070;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!reqReady && !rspValid, "R12", "held off", {reqReady, rspValid}, 0);
    end
    reqValid = 1'b0; lpExit = 1'b1;
    @(negedge clk); lpExit = 1'b0;
    check(arrSleep == 1'b0, "R12", "exited", arrSleep, 0);
    check(reqReady == 1'b1, "R12", "unlocked", reqReady, 1);
    doRead(16'h0061, 3 + 4, 1'b1, "R12");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule